// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the fetch address of a single-cycle processor and chooses, on every clock, where the next instruction comes from. The address moves forward by one word (4 bytes) by default. A taken conditional branch adds a signed word offset, taken from the instruction's 16-bit immediate, to the incremented address. An unconditional jump builds a region-local absolute address from the instruction's 26-bit target field and the top bits of the incremented address.

The decoder supplies the branch and jump flags and the current instruction's fields. The ALU supplies the equality (zero) flag. The unit returns the registered fetch address and its word-incremented value. The choice is made by a three-way selector with named outcomes. `SEL_SEQ` means fall through. `SEL_BRANCH` is reached when the branch flag and the zero flag are both set. `SEL_JUMP` is reached whenever the jump flag is set. The registered address then takes the chosen value on the next rising edge. A synchronous reset overrides every outcome.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_o` becomes 0 after that edge, whatever the other inputs are.
- R2: `pc_plus4_o` always equals `pc_o + 4`, modulo 2^32.
- R3: With `branch_i` and `jump_i` both low, `pc_o` after the edge equals `pc_plus4_o` before it.
- R4: With `branch_i` and `zero_i` both high and `jump_i` low, the next `pc_o` is `pc_plus4_o` plus the 16-bit `imm_i` sign-extended to 32 bits and multiplied by 4. Bit 15 of `imm_i` is the sign bit.
- R5: With `branch_i` high and `zero_i` low and `jump_i` low, the next `pc_o` is `pc_plus4_o` (branch not taken).
- R6: `zero_i` has no effect on the next address when `branch_i` is low.
- R7: With `jump_i` high, the next `pc_o` is built as follows: bits 31..28 come from `pc_plus4_o[31:28]`, bits 27..2 are `target_i[25:0]`, and bits 1..0 are zero.
- R8: When `jump_i` is high, the jump address is used even if `branch_i` and `zero_i` are both high.
- R9: All address sums wrap modulo 2^32 with no error indication. For example, `0xFFFFFFFC` falls through to `0x00000000`, and a negative offset may cross below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the address register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imm_i | input | 16 | Immediate field of the current instruction (branch word offset) |
| target_i | input | 26 | Target field of the current instruction (jump word address) |
| branch_i | input | 1 | Current instruction is a conditional branch |
| jump_i | input | 1 | Current instruction is an unconditional jump |
| zero_i | input | 1 | ALU result was zero (operands equal) |
| pc_o | output | 32 | Current fetch address |
| pc_plus4_o | output | 32 | Current fetch address plus 4 |

## Verification
The bench builds the unit with its default widths: 32-bit address, 16-bit offset, 26-bit target, and a 2-bit word shift. This leaves exactly four preserved upper bits in a jump. Those widths make it possible to reach the sign bit of the offset and to walk the address into the top region by a large backward branch. A jump with an all-ones target then lands on `0xFFFFFFFC`, from which the wrap to zero and the kept upper nibble can both be observed. A behavioural reference, driven by directed and pseudo-random flag and field combinations, is compared against both outputs every cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;

    // Source of the next fetch address
    typedef enum logic [1:0] {
        SEL_SEQ    = 2'd0,
        SEL_BRANCH = 2'd1,
        SEL_JUMP   = 2'd2
    } nxt_sel_e;

    localparam int unsigned ADDR_W_DEF = 32;
    localparam int unsigned IMM_W_DEF  = 16;
    localparam int unsigned TGT_W_DEF  = 26;
    localparam int unsigned WORD_SH    = 2;

endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned STEP   = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] sum_o
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    // Wraps modulo 2^ADDR_W by width truncation
    always_comb begin
        sum_o = base_i + STEP_V;
    end

endmodule

// File: rtl/npc_branch_tgt.sv
module npc_branch_tgt #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 16,
    parameter int unsigned SH     = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [ADDR_W-1:0] tgt_o
);

    localparam int unsigned EXT_W = ADDR_W - IMM_W - SH;

    logic [ADDR_W-1:0] offset;

    // Sign-extend, then scale words to bytes
    always_comb begin
        offset = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, {SH{1'b0}}};
        tgt_o  = base_i + offset;
    end

endmodule

// File: rtl/npc_jump_tgt.sv
module npc_jump_tgt #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned TGT_W  = 26,
    parameter int unsigned SH     = 2
) (
    input  logic [ADDR_W-TGT_W-SH-1:0] hi_i,
    input  logic [TGT_W-1:0]           field_i,
    output logic [ADDR_W-1:0]          tgt_o
);

    always_comb begin
        tgt_o = {hi_i, field_i, {SH{1'b0}}};
    end

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              branch_i,
    input  logic              jump_i,
    input  logic              zero_i,
    input  logic [ADDR_W-1:0] seq_i,
    input  logic [ADDR_W-1:0] br_i,
    input  logic [ADDR_W-1:0] jmp_i,
    output nxt_sel_e          sel_o,
    output logic [ADDR_W-1:0] next_o
);

    // Outcome decode: jump outranks a taken branch
    always_comb begin
        if (jump_i) begin
            sel_o = SEL_JUMP;
        end else if (branch_i && zero_i) begin
            sel_o = SEL_BRANCH;
        end else begin
            sel_o = SEL_SEQ;
        end
    end

    // Address steering per outcome
    always_comb begin
        unique case (sel_o)
            SEL_JUMP:   next_o = jmp_i;
            SEL_BRANCH: next_o = br_i;
            default:    next_o = seq_i;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned IMM_W  = IMM_W_DEF,
    parameter int unsigned TGT_W  = TGT_W_DEF,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [TGT_W-1:0]  target_i,
    input  logic              branch_i,
    input  logic              jump_i,
    input  logic              zero_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] pc_plus4_o
);

    localparam int unsigned STEP   = 1 << WORD_SH;
    localparam int unsigned KEEP_W = ADDR_W - TGT_W - WORD_SH;
    localparam int unsigned EXT_W  = ADDR_W - IMM_W - WORD_SH;

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_addr;
    logic [ADDR_W-1:0] jmp_addr;
    logic [ADDR_W-1:0] pc_d;
    nxt_sel_e          sel;

    npc_incr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_incr (
        .base_i (pc_q),
        .sum_o  (seq_addr)
    );

    npc_branch_tgt #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SH(WORD_SH)) u_br (
        .base_i (seq_addr),
        .imm_i  (imm_i),
        .tgt_o  (br_addr)
    );

    npc_jump_tgt #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .SH(WORD_SH)) u_jmp (
        .hi_i    (seq_addr[ADDR_W-1 -: KEEP_W]),
        .field_i (target_i),
        .tgt_o   (jmp_addr)
    );

    npc_select #(.ADDR_W(ADDR_W)) u_sel (
        .branch_i (branch_i),
        .jump_i   (jump_i),
        .zero_i   (zero_i),
        .seq_i    (seq_addr),
        .br_i     (br_addr),
        .jmp_i    (jmp_addr),
        .sel_o    (sel),
        .next_o   (pc_d)
    );

    // Address register
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_d;
        end
    end

    // Outputs
    always_comb begin
        pc_o       = pc_q;
        pc_plus4_o = seq_addr;
    end

    p_reset_value_r1: assert property (@(posedge clk)
        rst |=> pc_o == RESET_PC)
        else $error("reset value");

    p_incr_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (pc_plus4_o - pc_o) == ADDR_W'(STEP))
        else $error("increment gap");

    p_fall_through_r3: assert property (@(posedge clk) disable iff (rst)
        (!jump_i && !(branch_i && zero_i)) |=> pc_o == $past(pc_plus4_o))
        else $error("fall through");

    p_branch_taken_r4: assert property (@(posedge clk) disable iff (rst)
        (branch_i && zero_i && !jump_i) |=>
        pc_o == $past(pc_plus4_o)
              + {{EXT_W{$past(imm_i[IMM_W-1])}}, $past(imm_i), {WORD_SH{1'b0}}})
        else $error("branch target");

    p_jump_form_r7: assert property (@(posedge clk) disable iff (rst)
        jump_i |=> (pc_o[WORD_SH-1:0] == '0)
                && (pc_o[ADDR_W-1 -: KEEP_W] == $past(pc_plus4_o[ADDR_W-1 -: KEEP_W]))
                && (pc_o[WORD_SH +: TGT_W] == $past(target_i)))
        else $error("jump target");

    p_jump_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (jump_i && branch_i && zero_i) |-> sel == SEL_JUMP)
        else $error("jump priority");

    p_top_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (pc_o == '1 - ADDR_W'(STEP - 1) && !jump_i && !branch_i) |=> pc_o == '0)
        else $error("wrap to zero");

endmodule

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] imm_i = '0;
    logic [25:0] target_i = '0;
    logic        branch_i = 1'b0;
    logic        jump_i = 1'b0;
    logic        zero_i = 1'b0;
    logic [31:0] pc_o;
    logic [31:0] pc_plus4_o;

    int          vecs = 0;
    int          miss = 0;
    bit          done = 1'b0;
    logic [31:0] ref_pc = '0;

    always #(CLK_P/2) clk = ~clk;

    npc_unit dut_i (
        .clk        (clk),
        .rst        (rst),
        .imm_i      (imm_i),
        .target_i   (target_i),
        .branch_i   (branch_i),
        .jump_i     (jump_i),
        .zero_i     (zero_i),
        .pc_o       (pc_o),
        .pc_plus4_o (pc_plus4_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one instruction, advance the model, compare after the edge
    task automatic step(string tag, bit b, bit j, bit z,
                        logic [15:0] im, logic [25:0] tg);
        logic [31:0] p4;
        @(negedge clk);
        rst = 1'b0; branch_i = b; jump_i = j; zero_i = z;
        imm_i = im; target_i = tg;
        p4 = ref_pc + 32'd4;
        if (j)
            ref_pc = {p4[31:28], tg, 2'b00};
        else if (b && z)
            ref_pc = p4 + 32'($signed(im)) * 32'd4;
        else
            ref_pc = p4;
        @(posedge clk);
        #(CLK_P/4);
        check(tag, pc_o, ref_pc);
        check("R2 incremented output", pc_plus4_o, ref_pc + 32'd4);
    endtask

    task automatic do_reset(bit j);
        @(negedge clk);
        rst = 1'b1; jump_i = j; target_i = 26'h155_5555;
        branch_i = j; zero_i = j;
        @(posedge clk);
        #(CLK_P/4);
        ref_pc = '0;
        check("R1 reset", pc_o, 32'h0);
        check("R2 incremented output at reset", pc_plus4_o, 32'h4);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #(CLK_P/4);
        check("R1 reset", pc_o, 32'h0);

        step("R3 sequential", 0, 0, 0, 16'h0000, 26'h0);
        step("R3 sequential", 0, 0, 0, 16'h7FFF, 26'h3FF_FFFF);
        step("R3 sequential", 0, 0, 0, 16'h0010, 26'h0);
        step("R6 zero ignored", 0, 0, 1, 16'h0040, 26'h0);
        step("R5 branch not taken", 1, 0, 0, 16'h0040, 26'h0);
        step("R4 forward branch", 1, 0, 1, 16'h0003, 26'h0);
        step("R4 backward branch", 1, 0, 1, 16'hFFFE, 26'h0);
        step("R7 jump", 0, 1, 0, 16'h0000, 26'h000_0100);
        step("R8 jump over branch", 1, 1, 1, 16'h0005, 26'h000_0020);
        step("R7 jump with zero", 0, 1, 1, 16'hFFFF, 26'h000_0040);
        step("R9 branch below zero", 1, 0, 1, 16'h8000, 26'h0);
        step("R7 jump keeps top nibble", 0, 1, 0, 16'h0, 26'h3FF_FFFF);
        step("R9 wrap to zero", 0, 0, 0, 16'h0, 26'h0);
        step("R9 backward wrap", 1, 0, 1, 16'hFFFD, 26'h0);
        step("R6 zero ignored", 0, 0, 1, 16'h8000, 26'h0);
        do_reset(1'b1);
        step("R3 after reset", 0, 0, 0, 16'h0, 26'h0);

        for (int k = 0; k < 300; k++) begin
            logic [3:0] f;
            f = 4'($urandom);
            step("mixed", f[0], f[1] & f[2], f[3],
                 16'($urandom), 26'($urandom));
            if (k == 150) do_reset(1'b0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            miss++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

endmodule